// File: doc/BRIEF.md
# Two-Wire Slave Protocol Engine

This block is the bus-facing front end of a two-wire serial slave. Both bus lines are brought into the system clock domain, synchronised and filtered. The engine finds start, repeated start and stop conditions and shifts bytes in and out most significant bit first. It pulls SDA low through an active-high pull-down enable when it acknowledges a byte or sends a zero data bit. It never drives SDA high and never generates or stretches SCL.

The first byte after any start is a selection byte. Its upper four bits must equal the fixed type code 1010 and its next three bits must equal the strapped select pins. Its last bit gives the direction, 1 for read and 0 for write. A transaction controller sits behind the engine. It receives a selection strobe with the direction, a strobe for each written byte, the master's acknowledge after each read byte, and a stop strobe. In read mode it supplies each byte on request. While the controller reports an internal write in progress, the selection byte is not acknowledged, which lets a master poll until the device is ready.

Top module: `tws_engine`

## Requirements
- R1: While reset is held, and right after it, the pull-down enable and all strobes (selection, byte received, read request, master acknowledge, stop) are low.
- R2: A selection byte whose bits 7..4 are 1010 and bits 3..1 equal the select pins is acknowledged: SDA is held low for the whole high period of the ninth clock, the selection strobe pulses once and the direction output takes bit 0.
- R3: A selection byte with a wrong type code or wrong select bits gets no acknowledge. Every later byte up to the next start is then neither acknowledged nor reported.
- R4: A selection byte that arrives while the busy input is high is not acknowledged. The same byte sent after busy has dropped is acknowledged.
- R5: In write mode each data byte is shown MSB first on the received-data output with a one-cycle valid strobe, and it is acknowledged.
- R6: In read mode a one-cycle read request is raised after the selection acknowledge. The byte on the read-data input in the following cycle is sent MSB first. The pull-down enable changes only while filtered SCL is low.
- R7: The master's ninth bit after each read byte is reported with a strobe (ack flag 1 for low, 0 for high). An ack requests the next byte. A nack releases SDA and causes no further request until the next start.
- R8: A repeated start during a transfer restarts selection-byte reception without a stop, so a write of one byte followed by a read selection works as a random read.
- R9: A stop condition in any state releases SDA, returns the engine to idle and pulses the stop strobe.
- R10: A start in the middle of a byte discards the partial byte and restarts selection. After an abandoned read, nine clocks with SDA released followed by a start leave the engine able to acknowledge a new selection.
- R11: A pulse on SCL shorter than the filter length, in system clocks, is ignored and shifts no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pd_o | output | 1 | Pull-down enable for SDA, 1 pulls the line low |
| dev_pins_i | input | 3 | Strapped select pins compared with selection bits 3..1 |
| wr_busy_i | input | 1 | Back end internal write in progress |
| sel_o | output | 1 | One-cycle strobe: selection byte acknowledged |
| rw_o | output | 1 | Direction of the current transfer, 1 read |
| rx_data_o | output | 8 | Last data byte received in write mode |
| rx_valid_o | output | 1 | One-cycle strobe: rx_data_o holds a new byte |
| rd_req_o | output | 1 | One-cycle request for the next read byte |
| rd_data_i | input | 8 | Read byte, sampled the cycle after rd_req_o |
| mack_valid_o | output | 1 | One-cycle strobe: master's ninth bit sampled |
| mack_o | output | 1 | Master's response, 1 ack, 0 nack |
| stop_o | output | 1 | One-cycle strobe on a stop condition |

## Verification
The hardest state to reach from the ports is an engine that has been left in the middle of a read. In that state it may be holding SDA low, and the master has to recover it with free clocks before a start can be seen. The stimulus starts a read, clocks only three of the data bits and then gives nine clocks with SDA released. This passes the abandoned byte and its nack bit, and the bench checks that a new selection is then acknowledged and that exactly one read byte was fetched. A start inserted after four bits of a data byte, and an SCL glitch two system clocks long placed just before a selection byte, reach the other corners.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;
  localparam int PIN_W  = 3;
  localparam int CODE_W = BYTE_W - 1 - PIN_W;
  localparam logic [CODE_W-1:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_LOAD,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } tws_state_e;
endpackage

// File: rtl/tws_line_filter.sv
module tws_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_o) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        line_o <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tws_bus_events.sv
module tws_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic cond_start,
  output logic cond_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise   = scl_f & ~scl_q;
  assign scl_fall   = ~scl_f & scl_q;
  assign cond_start = scl_f & scl_q & sda_q & ~sda_f;
  assign cond_stop  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/tws_engine.sv
module tws_engine
  import tws_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pd_o,
  input  logic [PIN_W-1:0]  dev_pins_i,
  input  logic              wr_busy_i,
  output logic              sel_o,
  output logic              rw_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rd_req_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              mack_valid_o,
  output logic              mack_o,
  output logic              stop_o
);
  localparam int BCW = $clog2(BYTE_W + 1);
  localparam logic [BCW-1:0] BIT_FULL = BCW'(BYTE_W);
  localparam logic [BCW-1:0] BIT_LAST = BCW'(BYTE_W - 1);

  logic [1:0] raw_lines, filt_lines;
  logic       scl_f, sda_f;
  logic       ev_rise, ev_fall, ev_start, ev_stop;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    tws_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  tws_bus_events u_events (
    .clk        (clk),
    .rst        (rst),
    .scl_f      (scl_f),
    .sda_f      (sda_f),
    .scl_rise   (ev_rise),
    .scl_fall   (ev_fall),
    .cond_start (ev_start),
    .cond_stop  (ev_stop)
  );

  tws_state_e        state_q;
  logic [BCW-1:0]    bit_cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q;
  logic              addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1 -: CODE_W] == DEV_TYPE) &&
                    (sh_q[PIN_W:1] == dev_pins_i) && !wr_busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      bit_cnt_q    <= '0;
      sh_q         <= '0;
      tx_q         <= '0;
      sda_pd_o     <= 1'b0;
      sel_o        <= 1'b0;
      rw_o         <= 1'b0;
      rx_data_o    <= '0;
      rx_valid_o   <= 1'b0;
      rd_req_o     <= 1'b0;
      mack_valid_o <= 1'b0;
      mack_o       <= 1'b0;
      stop_o       <= 1'b0;
    end else begin
      sel_o        <= 1'b0;
      rx_valid_o   <= 1'b0;
      rd_req_o     <= 1'b0;
      mack_valid_o <= 1'b0;
      stop_o       <= 1'b0;
      if (ev_start) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        sda_pd_o  <= 1'b0;
      end else if (ev_stop) begin
        state_q  <= ST_IDLE;
        sda_pd_o <= 1'b0;
        stop_o   <= 1'b1;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR_BYTE: begin
            if (ev_rise) begin
              sh_q      <= {sh_q[BYTE_W-2:0], sda_f};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (ev_fall && bit_cnt_q == BIT_FULL) begin
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  sda_pd_o <= 1'b1;
                  rw_o     <= sh_q[0];
                  sel_o    <= 1'b1;
                  state_q  <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IGNORE;
                end
              end else begin
                rx_data_o  <= sh_q;
                rx_valid_o <= 1'b1;
                sda_pd_o   <= 1'b1;
                state_q    <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (ev_fall) begin
              sda_pd_o  <= 1'b0;
              bit_cnt_q <= '0;
              if (rw_o) begin
                rd_req_o <= 1'b1;
                state_q  <= ST_LOAD;
              end else begin
                state_q <= ST_WR_BYTE;
              end
            end
          end
          ST_WR_ACK: begin
            if (ev_fall) begin
              sda_pd_o  <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ST_WR_BYTE;
            end
          end
          ST_LOAD: begin
            tx_q      <= rd_data_i;
            sda_pd_o  <= ~rd_data_i[BYTE_W-1];
            bit_cnt_q <= '0;
            state_q   <= ST_RD_BYTE;
          end
          ST_RD_BYTE: begin
            if (ev_fall) begin
              if (bit_cnt_q == BIT_LAST) begin
                sda_pd_o <= 1'b0;
                state_q  <= ST_RD_ACK;
              end else begin
                tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
                sda_pd_o  <= ~tx_q[BYTE_W-2];
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (ev_rise) begin
              mack_valid_o <= 1'b1;
              mack_o       <= ~sda_f;
            end else if (ev_fall) begin
              if (mack_o) begin
                rd_req_o <= 1'b1;
                state_q  <= ST_LOAD;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tws_engine_chk.sv
module tws_engine_chk (
  input logic clk,
  input logic rst,
  input logic scl_f,
  input logic sda_pd_o,
  input logic sel_o,
  input logic wr_busy_i,
  input logic rx_valid_o,
  input logic rd_req_o,
  input logic mack_valid_o,
  input logic stop_o
);
  // R6
  pd_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pd_o) |-> !scl_f);
  // R6
  rd_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |=> !rd_req_o);
  // R5
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);
  // R2
  sel_ack_chk: assert property (@(posedge clk) disable iff (rst)
    sel_o |-> sda_pd_o);
  // R4
  sel_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    sel_o |-> !$past(wr_busy_i));
  // R7
  mack_released_chk: assert property (@(posedge clk) disable iff (rst)
    mack_valid_o |-> !sda_pd_o);
  // R9
  stop_released_chk: assert property (@(posedge clk) disable iff (rst)
    stop_o |-> !sda_pd_o);
endmodule

bind tws_engine tws_engine_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .scl_f        (scl_f),
  .sda_pd_o     (sda_pd_o),
  .sel_o        (sel_o),
  .wr_busy_i    (wr_busy_i),
  .rx_valid_o   (rx_valid_o),
  .rd_req_o     (rd_req_o),
  .mack_valid_o (mack_valid_o),
  .stop_o       (stop_o)
);

// File: tb/tws_engine_tb.sv
module tws_engine_tb;
  localparam int Q = 20;
  localparam logic [7:0] SEL_W   = 8'hAA;
  localparam logic [7:0] SEL_R   = 8'hAB;
  localparam logic [7:0] BAD_PIN = 8'hA8;
  localparam logic [7:0] BAD_TYP = 8'hBA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic sda_pd_o, sel_o, rw_o, rx_valid_o, rd_req_o, mack_valid_o, mack_o, stop_o;
  logic [7:0] rx_data_o, rd_data_i;
  logic [2:0] pins = 3'b101;
  logic wr_busy = 1'b0;

  int checks = 0, errors = 0;
  int sel_cnt = 0, stop_cnt = 0, ack_cnt = 0, nack_cnt = 0, rd_cnt = 0;
  int reads = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pd_o;

  function automatic logic [7:0] rdpat(int k);
    return 8'(8'h96 ^ (k * 59));
  endfunction

  assign rd_data_i = rdpat(rd_cnt);

  tws_engine u_dut (
    .clk (clk), .rst (rst), .scl_i (scl_m), .sda_i (sda_line),
    .sda_pd_o (sda_pd_o), .dev_pins_i (pins), .wr_busy_i (wr_busy),
    .sel_o (sel_o), .rw_o (rw_o), .rx_data_o (rx_data_o),
    .rx_valid_o (rx_valid_o), .rd_req_o (rd_req_o), .rd_data_i (rd_data_i),
    .mack_valid_o (mack_valid_o), .mack_o (mack_o), .stop_o (stop_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard and strobe counters
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid_o) begin
        if (exp_q.size() == 0) chk(0, "R3/R5 unexpected byte", int'(rx_data_o), -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_data_o == e, "R5 received byte", int'(rx_data_o), int'(e));
        end
      end
      if (sel_o) sel_cnt++;
      if (stop_o) stop_cnt++;
      if (rd_req_o) rd_cnt++;
      if (mack_valid_o) begin
        if (mack_o) ack_cnt++;
        else nack_cnt++;
      end
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b, output logic r);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    r = sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
    clock_bit(1'b1, r);
    acked = ~r;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, r);
      v[i] = r;
    end
    clock_bit(~give_ack, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] v;
    logic r;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!sda_pd_o && !sel_o && !rx_valid_o && !rd_req_o && !mack_valid_o && !stop_o,
        "R1 reset outputs", int'(sda_pd_o), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sda_pd_o && !stop_o, "R1 after reset", int'(sda_pd_o), 0);

    // R2 / R5 write session
    bus_start();
    wr_byte(SEL_W, a);
    chk(a, "R2 selection ack", int'(a), 1);
    chk(rw_o == 1'b0, "R2 direction write", int'(rw_o), 0);
    chk(sel_cnt == 1, "R2 selection strobe", sel_cnt, 1);
    exp_q.push_back(8'h5A);
    wr_byte(8'h5A, a);
    chk(a, "R5 data ack 1", int'(a), 1);
    exp_q.push_back(8'hC3);
    wr_byte(8'hC3, a);
    chk(a, "R5 data ack 2", int'(a), 1);
    bus_stop();
    wq();
    chk(exp_q.size() == 0, "R5 all bytes seen", exp_q.size(), 0);
    chk(stop_cnt == 1, "R9 stop strobe", stop_cnt, 1);
    chk(!sda_pd_o, "R9 released", int'(sda_pd_o), 0);

    // R3 mismatches
    bus_start();
    wr_byte(BAD_PIN, a);
    chk(!a, "R3 wrong pins nack", int'(a), 0);
    wr_byte(8'h00, a);
    chk(!a, "R3 later byte nack", int'(a), 0);
    bus_stop();
    bus_start();
    wr_byte(BAD_TYP, a);
    chk(!a, "R3 wrong type nack", int'(a), 0);
    bus_stop();
    chk(sel_cnt == 1, "R3 no selection", sel_cnt, 1);

    // R4 busy polling
    wr_busy = 1'b1;
    bus_start();
    wr_byte(SEL_W, a);
    chk(!a, "R4 busy nack", int'(a), 0);
    bus_stop();
    wr_busy = 1'b0;
    bus_start();
    wr_byte(SEL_W, a);
    chk(a, "R4 ack after busy", int'(a), 1);
    bus_stop();

    // R6 / R7 sequential read
    bus_start();
    wr_byte(SEL_R, a);
    chk(a && rw_o, "R6 read selection", int'({a, rw_o}), 3);
    for (int k = 0; k < 3; k++) begin
      rd_byte(k != 2, v);
      chk(v == rdpat(reads + 1), "R6 read byte", int'(v), int'(rdpat(reads + 1)));
      reads++;
    end
    chk(ack_cnt == 2 && nack_cnt == 1, "R7 master response", ack_cnt * 16 + nack_cnt, 33);
    chk(rd_cnt == reads, "R7 requests", rd_cnt, reads);
    rd_byte(1'b0, v);
    chk(v == 8'hFF, "R7 released after nack", int'(v), 8'hFF);
    chk(rd_cnt == reads, "R7 no request after nack", rd_cnt, reads);
    bus_stop();

    // R8 random read
    bus_start();
    wr_byte(SEL_W, a);
    exp_q.push_back(8'h10);
    wr_byte(8'h10, a);
    bus_start();
    wr_byte(SEL_R, a);
    chk(a && rw_o, "R8 repeated start read", int'({a, rw_o}), 3);
    rd_byte(1'b0, v);
    chk(v == rdpat(reads + 1), "R8 read byte", int'(v), int'(rdpat(reads + 1)));
    reads++;
    bus_stop();
    chk(exp_q.size() == 0, "R8 address byte seen", exp_q.size(), 0);

    // R10 start in the middle of a byte
    bus_start();
    wr_byte(SEL_W, a);
    for (int i = 0; i < 4; i++) clock_bit(1'b0, r);
    bus_start();
    wr_byte(SEL_W, a);
    chk(a, "R10 restart mid-byte", int'(a), 1);
    exp_q.push_back(8'h77);
    wr_byte(8'h77, a);
    bus_stop();
    chk(exp_q.size() == 0, "R10 partial dropped", exp_q.size(), 0);

    // R10 recovery from an abandoned read
    bus_start();
    wr_byte(SEL_R, a);
    reads++;
    for (int i = 0; i < 3; i++) clock_bit(1'b1, r);
    for (int i = 0; i < 9; i++) clock_bit(1'b1, r);
    bus_start();
    wr_byte(SEL_W, a);
    chk(a, "R10 recovery ack", int'(a), 1);
    bus_stop();
    chk(rd_cnt == reads, "R10 single fetch", rd_cnt, reads);

    // R11 SCL glitch before a selection byte
    bus_start();
    sda_m = 1'b0; wq();
    scl_m = 1'b1;
    repeat (2) @(negedge clk);
    scl_m = 1'b0; wq();
    wr_byte(SEL_W, a);
    chk(a, "R11 glitch ignored", int'(a), 1);
    bus_stop();
    wq();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule